// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A memory-mapped watchdog that watches a free-running 64-bit system count supplied from outside. Software arms it by programming a 32-bit period and enabling it; the block then holds an absolute 64-bit deadline. When the count reaches the deadline, a warning level (stage 0) rises and a fresh deadline one period later is set. If software still does nothing, the count reaching that second deadline raises the reset level (stage 1). Any refresh pushes the deadline one period past the current count and drops both levels.

Software reaches the block through a single-cycle register port with a frame-select input. Frame 0 is the control frame: control/status, period, and the deadline as two 32-bit words. Frame 1 is the refresh frame: a write of any value to its first word is a refresh. Both frames also expose two read-only identification constants. Read data is combinational from the address. Stage 0 is intended for an interrupt controller and stage 1 for a system reset generator. Both are outside this block.

Top module: `wdog_two_stage`

## Requirements
- R1: After rst_ni is released, the control/status, period and both deadline words read 0, and stage0_o and stage1_o are low.
- R2: Frame 0 (frame_i=0) maps control/status at 0x000, the period at 0x008, the deadline low word at 0x010 and the high word at 0x014. Control/status packs enable in bit 0, stage-0 status in bit 1 and stage-1 status in bit 2. Frame 1 (frame_i=1) maps the refresh word at 0x000, which reads 0. Unmapped offsets read 0.
- R3: Offset 0xFCC returns the IFACE_ID parameter and offset 0xFD0 returns the BLOCK_ID parameter, in either frame. Writes to these offsets have no effect.
- R4: Any write to refresh-frame offset 0x000 loads the deadline with cnt_i + period, with cnt_i sampled in the write cycle, and clears both status bits.
- R5: A write to control/status sets enable from data bit 0 and is always a refresh. Data bits 1 and 2 of that write are ignored.
- R6: A write to the period register stores it. While enabled, the write is also a refresh that uses the new period. While disabled, the deadline is left unchanged.
- R7: When enabled with stage 0 clear, a clock edge at which cnt_i >= deadline sets stage 0 and reloads the deadline with cnt_i + period.
- R8: When enabled with stage 0 set, a clock edge at which cnt_i >= deadline sets stage 1 and leaves the deadline unchanged.
- R9: While enable is 0, the deadline is never compared, and neither stage output rises.
- R10: A write to a deadline word loads that 32-bit word directly, leaves the other word unchanged, and clears stage 0.
- R11: stage0_o and stage1_o are registered levels equal to status bits 1 and 2.
- R12: The reload sum is a full 64-bit addition, so a carry out of the low word reaches the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W (64) | Free-running system count |
| req_i | input | 1 | Register access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| frame_i | input | 1 | 0 = control frame, 1 = refresh frame |
| addr_i | input | 12 | Byte offset within the frame |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational from frame_i and addr_i |
| stage0_o | output | 1 | Warning level (first expiry) |
| stage1_o | output | 1 | Reset level (second expiry) |

## Verification
The bench checks the stage outputs at the exact expiry boundary. In the cycle where the count equals the deadline the output must still be low, and one cycle later it must be high. An off-by-one comparison or an unregistered output fails one of these two samples.

It checks that a period write while disabled leaves the deadline untouched, and that the same write while enabled re-arms the deadline with the new period. A design that always re-arms, or that re-arms with the old period, reads back the wrong deadline.

Other checks look for faults that could pass unnoticed elsewhere:
- The count starts just below a 32-bit boundary and a period close to 2^32 is used. A reload that drops the carry into the high word reads back a wrong high word.
- A direct deadline write is made after a first expiry. A design that does not clear stage 0 on this write keeps stage0_o high.
- A control write with bits 1 and 2 set is made. A design that lets software set these status bits reads them back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_CTRL    = 12'h000;
  localparam logic [REG_AW-1:0] OFS_PERIOD  = 12'h008;
  localparam logic [REG_AW-1:0] OFS_DLINE   = 12'h010;
  localparam logic [REG_AW-1:0] OFS_REFRESH = 12'h000;
  localparam logic [REG_AW-1:0] OFS_IFACE   = 12'hFCC;
  localparam logic [REG_AW-1:0] OFS_BLKID   = 12'hFD0;

  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_ST0 = 1;
  localparam int unsigned BIT_ST1 = 2;

  typedef struct packed {
    logic any;      // any write this cycle
    logic refresh;  // refresh-frame word 0
    logic ctrl;     // control/status
    logic period;   // period register
  } wr_evt_t;
endpackage

// File: rtl/wdog_bus_dec.sv
module wdog_bus_dec
  import wdog_pkg::*;
#(
  parameter int unsigned NW = 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              frame_i,
  input  logic [REG_AW-1:0] addr_i,
  output wr_evt_t           evt_o,
  output logic [NW-1:0]     dline_wr_o
);
  logic wr, ctl_fr;

  assign wr     = req_i & we_i;
  assign ctl_fr = ~frame_i;

  assign evt_o.any     = wr;
  assign evt_o.refresh = wr & frame_i & (addr_i == OFS_REFRESH);
  assign evt_o.ctrl    = wr & ctl_fr & (addr_i == OFS_CTRL);
  assign evt_o.period  = wr & ctl_fr & (addr_i == OFS_PERIOD);

  for (genvar w = 0; w < NW; w++) begin : g_dline_dec
    assign dline_wr_o[w] = wr & ctl_fr & (addr_i == OFS_DLINE + REG_AW'(4 * w));
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CW = 64,
  parameter int unsigned DW = 32,
  localparam int unsigned NW = CW / DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  wr_evt_t       evt_i,
  input  logic [NW-1:0] dline_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          en_o,
  output logic          st0_o,
  output logic          st1_o,
  output logic [DW-1:0] period_o,
  output logic [CW-1:0] dline_o
);
  logic          en_q, st0_q, st1_q;
  logic [DW-1:0] period_q, period_src;
  logic [CW-1:0] dline_q, reload, dline_wval;
  logic          refresh, hit;

  // a period write re-arms with the value being written
  assign period_src = evt_i.period ? wdata_i : period_q;
  assign reload     = cnt_i + CW'(period_src);
  assign refresh    = evt_i.refresh | evt_i.ctrl | (evt_i.period & en_q);
  // bus writes take priority over expiry in the same cycle
  assign hit        = en_q & (cnt_i >= dline_q) & ~evt_i.any;

  for (genvar w = 0; w < NW; w++) begin : g_dline_word
    assign dline_wval[w*DW +: DW] = dline_wr_i[w] ? wdata_i : dline_q[w*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      st0_q    <= 1'b0;
      st1_q    <= 1'b0;
      period_q <= '0;
      dline_q  <= '0;
    end else begin
      if (evt_i.ctrl)   en_q     <= wdata_i[BIT_EN];
      if (evt_i.period) period_q <= wdata_i;
      if (refresh) begin
        dline_q <= reload;
        st0_q   <= 1'b0;
        st1_q   <= 1'b0;
      end else if (|dline_wr_i) begin
        dline_q <= dline_wval;
        st0_q   <= 1'b0;
      end else if (hit) begin
        if (!st0_q) begin
          st0_q   <= 1'b1;
          dline_q <= reload;
        end else begin
          st1_q   <= 1'b1;
        end
      end
    end
  end

  assign en_o     = en_q;
  assign st0_o    = st0_q;
  assign st1_o    = st1_q;
  assign period_o = period_q;
  assign dline_o  = dline_q;
endmodule

// File: rtl/wdog_rd_mux.sv
module wdog_rd_mux
  import wdog_pkg::*;
#(
  parameter int unsigned CW        = 64,
  parameter int unsigned DW        = 32,
  parameter logic [31:0] IFACE_ID  = 32'h5744_0001,
  parameter logic [31:0] BLOCK_ID  = 32'h0000_0A17,
  localparam int unsigned NW = CW / DW
) (
  input  logic              frame_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              en_i,
  input  logic              st0_i,
  input  logic              st1_i,
  input  logic [DW-1:0]     period_i,
  input  logic [CW-1:0]     dline_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_IFACE) begin
      rdata_o = DW'(IFACE_ID);
    end else if (addr_i == OFS_BLKID) begin
      rdata_o = DW'(BLOCK_ID);
    end else if (!frame_i) begin
      if (addr_i == OFS_CTRL) begin
        rdata_o[BIT_EN]  = en_i;
        rdata_o[BIT_ST0] = st0_i;
        rdata_o[BIT_ST1] = st1_i;
      end else if (addr_i == OFS_PERIOD) begin
        rdata_o = period_i;
      end
      for (int w = 0; w < NW; w++) begin
        if (addr_i == OFS_DLINE + REG_AW'(4 * w)) rdata_o = dline_i[w*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] IFACE_ID = 32'h5744_0001,
  parameter logic [31:0] BLOCK_ID = 32'h0000_0A17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              frame_i,
  input  logic [11:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stage0_o,
  output logic              stage1_o
);
  localparam int unsigned NW = CNT_W / DATA_W;

  wr_evt_t           wr_evt;
  logic [NW-1:0]     dline_wr;
  logic              en, st0, st1;
  logic [DATA_W-1:0] period;
  logic [CNT_W-1:0]  dline;

  wdog_bus_dec #(.NW(NW)) i_dec (
    .req_i      (req_i),
    .we_i       (we_i),
    .frame_i    (frame_i),
    .addr_i     (addr_i),
    .evt_o      (wr_evt),
    .dline_wr_o (dline_wr)
  );

  wdog_core #(.CW(CNT_W), .DW(DATA_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_i),
    .evt_i      (wr_evt),
    .dline_wr_i (dline_wr),
    .wdata_i    (wdata_i),
    .en_o       (en),
    .st0_o      (st0),
    .st1_o      (st1),
    .period_o   (period),
    .dline_o    (dline)
  );

  wdog_rd_mux #(
    .CW(CNT_W), .DW(DATA_W), .IFACE_ID(IFACE_ID), .BLOCK_ID(BLOCK_ID)
  ) i_rd (
    .frame_i  (frame_i),
    .addr_i   (addr_i),
    .en_i     (en),
    .st0_i    (st0),
    .st1_i    (st1),
    .period_i (period),
    .dline_i  (dline),
    .rdata_o  (rdata_o)
  );

  assign stage0_o = st0;
  assign stage1_o = st1;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CW = 64,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] cnt_i,
  input wr_evt_t       evt_i,
  input logic          en_i,
  input logic [DW-1:0] period_i,
  input logic [CW-1:0] dline_i,
  input logic          stage0_o,
  input logic          stage1_o
);
  a_r4_refresh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.refresh |=> (!stage0_o && !stage1_o));

  a_r6_period_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.period && !en_i) |=> $stable(dline_i));

  a_r7_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage0_o) |-> (dline_i == $past(cnt_i) + CW'(period_i)));

  a_r8_after_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage1_o) |-> $past(stage0_o));

  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !stage0_o) |=> !stage0_o);
endmodule

bind wdog_two_stage wdog_chk #(.CW(CNT_W), .DW(DATA_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt_i),
  .evt_i    (wr_evt),
  .en_i     (en),
  .period_i (period),
  .dline_i  (dline),
  .stage0_o (stage0_o),
  .stage1_o (stage1_o)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] T_IFACE = 32'h1234_ABCD;
  localparam logic [31:0] T_BLKID = 32'h0000_5EED;
  localparam logic [11:0] A_CTRL = 12'h000, A_PER = 12'h008, A_LO = 12'h010,
                          A_HI = 12'h014, A_IF = 12'hFCC, A_ID = 12'hFD0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = 64'h0000_0001_FFFF_FF00;
  logic        req = 1'b0, we = 1'b0, frame = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        st0, st1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cnt <= cnt + 64'd1;

  wdog_two_stage #(.IFACE_ID(T_IFACE), .BLOCK_ID(T_BLKID)) i_wdog_two_stage (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .req_i(req), .we_i(we),
    .frame_i(frame), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .stage0_o(st0), .stage1_o(st1)
  );

  typedef struct { bit is_rd; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // monitor: compare queued expectations just after each falling edge
  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.is_rd ? rdata : {30'b0, st1, st0};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  // all tasks are entered and left at a falling edge
  task automatic wr(input bit fr, input logic [11:0] a, input logic [31:0] d,
                    output logic [63:0] snap);
    snap = cnt;
    req = 1'b1; we = 1'b1; frame = fr; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit fr, input logic [11:0] a, input logic [31:0] exp,
                    input string tag);
    req = 1'b1; we = 1'b0; frame = fr; addr = a;
    sbq.push_back('{is_rd: 1'b1, exp: exp, tag: tag});
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_st(input bit e0, input bit e1, input string tag);
    sbq.push_back('{is_rd: 1'b0, exp: {30'b0, e1, e0}, tag: tag});
  endtask

  task automatic wait_cnt(input logic [63:0] v);
    while (cnt < v) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  logic [63:0] s, s2, e, e2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, A_CTRL, 32'h0, "R1 ctrl after reset");
    rd(0, A_PER,  32'h0, "R1 period after reset");
    rd(0, A_LO,   32'h0, "R1 deadline lo after reset");
    rd(0, A_HI,   32'h0, "R1 deadline hi after reset");
    chk_st(0, 0, "R1 stages after reset");

    // R3 identification constants
    rd(0, A_IF, T_IFACE, "R3 iface id ctrl frame");
    rd(0, A_ID, T_BLKID, "R3 block id ctrl frame");
    rd(1, A_IF, T_IFACE, "R3 iface id refresh frame");
    rd(1, A_ID, T_BLKID, "R3 block id refresh frame");
    wr(0, A_IF, 32'h0, s);
    rd(0, A_IF, T_IFACE, "R3 id write ignored");

    // R2 map holes
    rd(1, 12'h000, 32'h0, "R2 refresh word reads 0");
    rd(0, 12'h004, 32'h0, "R2 unmapped reads 0");

    // R9 disabled: deadline 0 is far behind the count
    repeat (8) @(negedge clk);
    chk_st(0, 0, "R9 no expiry while disabled");

    // R6 period write while disabled
    wr(0, A_PER, 32'd40, s);
    rd(0, A_LO,  32'h0,  "R6 deadline unchanged while disabled");
    rd(0, A_PER, 32'd40, "R6 period stored");

    // R5 enable with stray status bits
    wr(0, A_CTRL, 32'h7, s);
    e = s + 64'd40;
    rd(0, A_CTRL, 32'h1, "R5 status bits ignored on write");
    rd(0, A_LO, e[31:0],  "R5 ctrl write refreshes lo");
    rd(0, A_HI, e[63:32], "R5 ctrl write refreshes hi");

    // R7 first expiry at the exact boundary
    wait_cnt(e);
    chk_st(0, 0, "R7 not yet expired");
    @(negedge clk);
    chk_st(1, 0, "R7 stage0 rises");
    rd(0, A_CTRL, 32'h3, "R11 status mirrors stage0");
    e2 = e + 64'd40;
    rd(0, A_LO, e2[31:0], "R7 deadline re-armed");

    // R8 second expiry
    wait_cnt(e2);
    chk_st(1, 0, "R8 not yet expired");
    @(negedge clk);
    chk_st(1, 1, "R8 stage1 rises");
    rd(0, A_CTRL, 32'h7, "R11 status mirrors stage1");
    rd(0, A_LO, e2[31:0], "R8 deadline held");

    // R4 refresh frame write
    wr(1, 12'h000, 32'hDEAD_BEEF, s);
    chk_st(0, 0, "R4 refresh clears both stages");
    e = s + 64'd40;
    rd(0, A_LO, e[31:0], "R4 refresh re-arms deadline");
    rd(0, A_CTRL, 32'h1, "R4 status cleared");

    // R12 and R6 enabled period write with wide carry
    wr(0, A_PER, 32'hFFFF_FFF0, s);
    e = s + 64'h0000_0000_FFFF_FFF0;
    rd(0, A_LO, e[31:0],  "R12 reload lo");
    rd(0, A_HI, e[63:32], "R12 carry into hi");

    // R10 direct deadline write clears stage0
    wr(0, A_PER, 32'd25, s);
    e = s + 64'd25;
    rd(0, A_LO, e[31:0], "R6 enabled period write refreshes with new value");
    wait_cnt(e + 64'd1);
    chk_st(1, 0, "R10 setup stage0");
    wr(0, A_HI, 32'h5, s2);
    chk_st(0, 0, "R10 deadline write clears stage0");
    rd(0, A_HI, 32'h5, "R10 hi word loaded");
    e2 = e + 64'd25;
    rd(0, A_LO, e2[31:0], "R10 lo word untouched");
    repeat (5) @(negedge clk);
    chk_st(0, 0, "R10 no expiry against future deadline");

    // R9 disable stops the watchdog
    wr(0, A_CTRL, 32'h0, s);
    e = s + 64'd25;
    rd(0, A_CTRL, 32'h0, "R9 enable cleared");
    wait_cnt(e + 64'd4);
    chk_st(0, 0, "R9 no stage after disable");
    rd(0, A_LO, e[31:0], "R9 deadline frozen");

    // R5 control write acts as refresh
    wr(0, A_CTRL, 32'h1, s);
    e = s + 64'd25;
    wait_cnt(e + 64'd1);
    chk_st(1, 0, "R5 setup stage0");
    wr(0, A_CTRL, 32'h1, s);
    chk_st(0, 0, "R5 ctrl write clears stage0");
    e = s + 64'd25;
    rd(0, A_LO, e[31:0], "R5 ctrl write re-arms");

    @(negedge clk);
    #2;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1-chain hung: act=running exp=done");
      summary();
      $finish;
    end
  end
endmodule